// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This combinational block sits between a 32-bit integer datapath and a data memory that is addressed by byte but read and written one full word at a time. On a load, it takes the word read from memory, the two low address bits and an access code. It extracts the byte, halfword or word being addressed and widens that value to 32 bits, using sign or zero fill. On a store, it places the low part of the register value onto the byte lanes the access covers, and it produces one write enable for each lane.

Lanes follow big-endian order: the byte at offset 0 is the most significant byte of the memory word. Two kinds of access raise a single misalignment flag instead of reaching memory. The first is an access whose address breaks the rule for its size. The second is an access that uses an undefined code. The address adder, the memory and any trap handling stay outside the block.

Top module: `mem_align`

## Requirements
- R1: A word access (code 3'b010) at offset 0 returns `memRdata` unchanged on `loadData`.
- R2: A byte load at offset k returns memory bits [31-8k : 24-8k], so offset 0 selects bits 31:24 and offset 3 selects bits 7:0.
- R3: Signed byte (3'b000) and signed halfword (3'b001) loads fill the upper bits of `loadData` with the top bit of the selected value.
- R4: Unsigned byte (3'b100) and unsigned halfword (3'b101) loads fill the upper bits of `loadData` with zeros.
- R5: A halfword load at offset 0 returns memory bits 31:16, and at offset 2 it returns bits 15:0.
- R6: For every defined code, `memWdata` does not depend on the offset. A byte store repeats `regWdata[7:0]` in all four lanes. A halfword store repeats `regWdata[15:0]` twice. A word store passes `regWdata` through unchanged.
- R7: `byteEn[3]` enables the lane at offset 0 and `byteEn[0]` the lane at offset 3. When `storeEn` is high and the access is aligned, exactly the addressed lanes are enabled: one for a byte, two for a halfword, four for a word. When `storeEn` is low, `byteEn` is 0.
- R8: `misalign` is 1 for a halfword access at an odd offset or a word access at a non-zero offset. While it is 1, `byteEn` is 0 and `loadData` is 0. Byte accesses are never misaligned.
- R9: The codes 3'b011, 3'b110 and 3'b111 are undefined. They behave as a misaligned access, with `misalign` at 1, `byteEn` at 0 and `loadData` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| storeEn | input | 1 | High for a store, low for a load |
| accType | input | 3 | Access code (size and signedness) |
| addrLow | input | 2 | Byte offset within the word |
| memRdata | input | 32 | Word read from memory |
| regWdata | input | 32 | Register value to be stored |
| loadData | output | 32 | Extended load result |
| memWdata | output | 32 | Lane-placed store data |
| byteEn | output | 4 | Per-lane write enables, bit 3 = offset 0 |
| misalign | output | 1 | Misaligned or undefined access |

## Verification
Directed cases read a word with a distinct value in every byte at each offset. A design that used little-endian lane order would return these bytes in reverse, and one that swapped the two bytes of a halfword would show the swap in the value. Negative bytes and negative halfwords are loaded under both signed and unsigned codes, which shows up any fill error in the upper 24 or 16 bits. Odd halfword offsets, non-zero word offsets and the three undefined codes are driven with `storeEn` high. A design that still enabled lanes for these cases would let a bad store reach memory. A random mix then covers every combination of code, offset and data against reference functions.

// File: rtl/mem_align_pkg.sv
package mem_align_pkg;

  typedef enum logic [2:0] {
    ACC_BYTE_S = 3'b000,
    ACC_HALF_S = 3'b001,
    ACC_WORD   = 3'b010,
    ACC_BYTE_U = 3'b100,
    ACC_HALF_U = 3'b101
  } accCode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    accSize_e size;
    logic     signExt;
    logic     fault;
  } alignStrobe_t;

endpackage

// File: rtl/mem_align_ctrl.sv
module mem_align_ctrl
  import mem_align_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [2:0]               accType,
  input  logic [$clog2(LANES)-1:0] addrLow,
  input  logic                     storeEn,
  output alignStrobe_t             strobe,
  output logic [LANES-1:0]         byteEn
);
  localparam int OFS_W = $clog2(LANES);

  logic     legal;
  logic     aligned;
  accSize_e size;
  logic     signExt;

  always_comb begin
    legal   = 1'b1;
    size    = SZ_WORD;
    signExt = 1'b0;
    case (accType)
      ACC_BYTE_S: begin size = SZ_BYTE; signExt = 1'b1; end
      ACC_BYTE_U: begin size = SZ_BYTE; signExt = 1'b0; end
      ACC_HALF_S: begin size = SZ_HALF; signExt = 1'b1; end
      ACC_HALF_U: begin size = SZ_HALF; signExt = 1'b0; end
      ACC_WORD:   begin size = SZ_WORD; signExt = 1'b0; end
      default:    legal = 1'b0;
    endcase
  end

  always_comb begin
    case (size)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~addrLow[0];
      default: aligned = (addrLow == '0);
    endcase
  end

  assign strobe.size    = size;
  assign strobe.signExt = signExt;
  assign strobe.fault   = ~(legal & aligned);

  // lane at offset i drives enable bit LANES-1-i (big-endian)
  for (genvar i = 0; i < LANES; i++) begin : g_lane_en
    localparam logic [OFS_W-1:0] OFS = OFS_W'(i);
    logic hit;
    always_comb begin
      case (size)
        SZ_BYTE: hit = (addrLow == OFS);
        SZ_HALF: hit = (addrLow[OFS_W-1:1] == OFS[OFS_W-1:1]);
        default: hit = 1'b1;
      endcase
    end
    assign byteEn[LANES-1-i] = hit & storeEn & ~strobe.fault;
  end

endmodule

// File: rtl/mem_align_datapath.sv
module mem_align_datapath
  import mem_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alignStrobe_t                    strobe,
  input  logic [$clog2(DATA_W/8)-1:0]     addrLow,
  input  logic [DATA_W-1:0]               memRdata,
  input  logic [DATA_W-1:0]               regWdata,
  output logic [DATA_W-1:0]               loadData,
  output logic [DATA_W-1:0]               memWdata
);
  localparam int BYTE_W = 8;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int LANES  = DATA_W / BYTE_W;
  localparam int OFS_W  = $clog2(LANES);

  logic [BYTE_W-1:0] laneByte [LANES];
  logic [BYTE_W-1:0] byteVal;
  logic [HALF_W-1:0] halfVal;
  logic [OFS_W-1:0]  hiIdx;
  logic [OFS_W-1:0]  loIdx;

  // offset i maps to the i-th byte counted from the MSB
  for (genvar i = 0; i < LANES; i++) begin : g_rd_lane
    assign laneByte[i] = memRdata[DATA_W-1-BYTE_W*i -: BYTE_W];
  end

  assign hiIdx   = {addrLow[OFS_W-1:1], 1'b0};
  assign loIdx   = {addrLow[OFS_W-1:1], 1'b1};
  assign byteVal = laneByte[addrLow];
  assign halfVal = {laneByte[hiIdx], laneByte[loIdx]};

  always_comb begin
    if (strobe.fault) begin
      loadData = '0;
    end else begin
      case (strobe.size)
        SZ_BYTE: loadData = {{(DATA_W-BYTE_W){strobe.signExt & byteVal[BYTE_W-1]}}, byteVal};
        SZ_HALF: loadData = {{(DATA_W-HALF_W){strobe.signExt & halfVal[HALF_W-1]}}, halfVal};
        default: loadData = memRdata;
      endcase
    end
  end

  // store data repeated on every lane; enables pick the live ones
  for (genvar i = 0; i < LANES; i++) begin : g_wr_lane
    always_comb begin
      case (strobe.size)
        SZ_BYTE: memWdata[BYTE_W*i +: BYTE_W] = regWdata[BYTE_W-1:0];
        SZ_HALF: memWdata[BYTE_W*i +: BYTE_W] = regWdata[BYTE_W*(i%2) +: BYTE_W];
        default: memWdata[BYTE_W*i +: BYTE_W] = regWdata[BYTE_W*i +: BYTE_W];
      endcase
    end
  end

endmodule

// File: rtl/mem_align.sv
module mem_align
  import mem_align_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          storeEn,
  input  logic [2:0]                    accType,
  input  logic [$clog2(DATA_W/8)-1:0]   addrLow,
  input  logic [DATA_W-1:0]             memRdata,
  input  logic [DATA_W-1:0]             regWdata,
  output logic [DATA_W-1:0]             loadData,
  output logic [DATA_W-1:0]             memWdata,
  output logic [DATA_W/8-1:0]           byteEn,
  output logic                          misalign
);
  localparam int LANES = DATA_W / 8;

  alignStrobe_t strobe;

  mem_align_ctrl #(.LANES(LANES)) u_ctrl (
    .accType (accType),
    .addrLow (addrLow),
    .storeEn (storeEn),
    .strobe  (strobe),
    .byteEn  (byteEn)
  );

  mem_align_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobe   (strobe),
    .addrLow  (addrLow),
    .memRdata (memRdata),
    .regWdata (regWdata),
    .loadData (loadData),
    .memWdata (memWdata)
  );

  assign misalign = strobe.fault;

endmodule

// File: rtl/mem_align_chk.sv
module mem_align_chk #(
  parameter int DATA_W = 32
) (
  input logic                          storeEn,
  input logic [2:0]                    accType,
  input logic [$clog2(DATA_W/8)-1:0]   addrLow,
  input logic [DATA_W-1:0]             memRdata,
  input logic [DATA_W-1:0]             regWdata,
  input logic [DATA_W-1:0]             loadData,
  input logic [DATA_W-1:0]             memWdata,
  input logic [DATA_W/8-1:0]           byteEn,
  input logic                          misalign
);
  always_comb begin
    a_r8_fault_blocks_write: assert (!misalign || byteEn == '0)
      else $error("misaligned access enabled lanes");
    a_r8_fault_zero_load: assert (!misalign || loadData == '0)
      else $error("misaligned access returned data");
    a_r7_no_enable_on_load: assert (storeEn || byteEn == '0)
      else $error("lanes enabled without store");
    a_r7_word_all_lanes: assert (!(storeEn && !misalign && accType == 3'b010) || (&byteEn))
      else $error("word store missing lanes");
    a_r7_byte_one_lane: assert (!(storeEn && (accType == 3'b000 || accType == 3'b100))
                                || $onehot0(byteEn) && byteEn != '0)
      else $error("byte store lane count");
    a_r1_word_passthrough: assert (!(accType == 3'b010 && !misalign) || loadData == memRdata)
      else $error("word load altered");
    a_r4_byte_zero_fill: assert (!(accType == 3'b100) || loadData[DATA_W-1:8] == '0)
      else $error("unsigned byte not zero filled");
    a_r3_byte_sign_fill: assert (!(accType == 3'b000) ||
                                 loadData[DATA_W-1:8] == {(DATA_W-8){loadData[7]}})
      else $error("signed byte fill wrong");
    a_r9_undefined_code: assert (!(accType == 3'b011 || accType[2:1] == 2'b11) || misalign)
      else $error("undefined code accepted");
  end
endmodule

bind mem_align mem_align_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mem_align.sv
module tb_mem_align;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        storeEn;
  logic [2:0]  accType;
  logic [1:0]  addrLow;
  logic [31:0] memRdata;
  logic [31:0] regWdata;
  logic [31:0] loadData;
  logic [31:0] memWdata;
  logic [3:0]  byteEn;
  logic        misalign;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_align dut (
    .storeEn(storeEn), .accType(accType), .addrLow(addrLow),
    .memRdata(memRdata), .regWdata(regWdata),
    .loadData(loadData), .memWdata(memWdata),
    .byteEn(byteEn), .misalign(misalign)
  );

  function automatic logic refMis(input logic [2:0] c, input logic [1:0] o);
    case (c)
      3'b000, 3'b100: return 1'b0;
      3'b001, 3'b101: return o[0];
      3'b010:         return (o != 2'd0);
      default:        return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] refLoad(input logic [2:0] c, input logic [1:0] o,
                                          input logic [31:0] rd);
    logic [31:0] b, h;
    b = (rd >> (8 * (3 - int'(o)))) & 32'hFF;
    h = (rd >> (8 * (2 - int'(o)))) & 32'hFFFF;
    if (refMis(c, o)) return 32'd0;
    case (c)
      3'b000: return b[7]  ? (b | 32'hFFFF_FF00) : b;
      3'b100: return b;
      3'b001: return h[15] ? (h | 32'hFFFF_0000) : h;
      3'b101: return h;
      default: return rd;
    endcase
  endfunction

  function automatic logic [31:0] refWdata(input logic [2:0] c, input logic [31:0] w);
    case (c)
      3'b000, 3'b100: return {4{w[7:0]}};
      3'b001, 3'b101: return {2{w[15:0]}};
      default:        return w;
    endcase
  endfunction

  function automatic logic [3:0] refBe(input logic st, input logic [2:0] c,
                                       input logic [1:0] o);
    if (!st || refMis(c, o)) return 4'b0000;
    case (c)
      3'b000, 3'b100: return 4'b1000 >> o;
      3'b001, 3'b101: return 4'b1100 >> o;
      default:        return 4'b1111;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (code=%b ofs=%0d st=%b)",
               tag, act, exp, accType, addrLow, storeEn);
    end
  endtask

  task automatic drive(input logic st, input logic [2:0] c, input logic [1:0] o,
                       input logic [31:0] rd, input logic [31:0] wd);
    @(posedge clk);
    storeEn = st; accType = c; addrLow = o; memRdata = rd; regWdata = wd;
    @(negedge clk);
  endtask

  // full comparison against reference functions
  task automatic applyAll(input logic st, input logic [2:0] c, input logic [1:0] o,
                          input logic [31:0] rd, input logic [31:0] wd);
    bit mis;
    string ltag;
    drive(st, c, o, rd, wd);
    mis = refMis(c, o);
    if (mis)                             ltag = "R8";
    else if (c == 3'b010)                ltag = "R1";
    else if (c == 3'b000 || c == 3'b001) ltag = "R3";
    else                                 ltag = "R4";
    chk(ltag, loadData, refLoad(c, o, rd));
    chk(mis ? "R8" : "R7", {28'd0, byteEn}, {28'd0, refBe(st, c, o)});
    chk((c == 3'b011 || c[2:1] == 2'b11) ? "R9" : "R8", {31'd0, misalign}, {31'd0, mis});
    if (!(c == 3'b011 || c[2:1] == 2'b11)) chk("R6", memWdata, refWdata(c, wd));
  endtask

  initial begin
    storeEn = 0; accType = 3'b010; addrLow = 0; memRdata = 0; regWdata = 0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // idle state: load, word, offset 0, zero data
    chk("R7", {28'd0, byteEn}, 32'd0);
    chk("R8", {31'd0, misalign}, 32'd0);

    // R2: big-endian byte pick
    drive(0, 3'b100, 2'd0, 32'h8192_A3B4, 0); chk("R2", loadData, 32'h0000_0081);
    drive(0, 3'b100, 2'd1, 32'h8192_A3B4, 0); chk("R2", loadData, 32'h0000_0092);
    drive(0, 3'b100, 2'd2, 32'h8192_A3B4, 0); chk("R2", loadData, 32'h0000_00A3);
    drive(0, 3'b100, 2'd3, 32'h8192_A3B4, 0); chk("R2", loadData, 32'h0000_00B4);
    drive(0, 3'b000, 2'd0, 32'h8192_A3B4, 0); chk("R3", loadData, 32'hFFFF_FF81);
    drive(0, 3'b000, 2'd3, 32'h8192_3B74, 0); chk("R3", loadData, 32'h0000_0074);
    // R5: halfword pick and extension
    drive(0, 3'b001, 2'd0, 32'h8192_A3B4, 0); chk("R5", loadData, 32'hFFFF_8192);
    drive(0, 3'b101, 2'd2, 32'h8192_A3B4, 0); chk("R5", loadData, 32'h0000_A3B4);
    drive(0, 3'b101, 2'd0, 32'h8192_A3B4, 0); chk("R4", loadData, 32'h0000_8192);
    drive(0, 3'b010, 2'd0, 32'hDEAD_BEEF, 0); chk("R1", loadData, 32'hDEAD_BEEF);
    // R6 / R7: store placement
    drive(1, 3'b000, 2'd2, 0, 32'h1234_56C7);
    chk("R6", memWdata, 32'hC7C7_C7C7); chk("R7", {28'd0, byteEn}, 32'h2);
    drive(1, 3'b001, 2'd2, 0, 32'h1234_56C7);
    chk("R6", memWdata, 32'h56C7_56C7); chk("R7", {28'd0, byteEn}, 32'h3);
    drive(1, 3'b101, 2'd0, 0, 32'h1234_56C7); chk("R7", {28'd0, byteEn}, 32'hC);
    drive(1, 3'b010, 2'd0, 0, 32'h1234_56C7);
    chk("R6", memWdata, 32'h1234_56C7); chk("R7", {28'd0, byteEn}, 32'hF);
    // R8: misaligned stores are blocked
    drive(1, 3'b001, 2'd1, 32'hFFFF_FFFF, 32'h1); chk("R8", {28'd0, byteEn}, 0);
    chk("R8", {31'd0, misalign}, 1); chk("R8", loadData, 0);
    drive(1, 3'b010, 2'd2, 32'hFFFF_FFFF, 32'h1); chk("R8", {28'd0, byteEn}, 0);
    // R9: undefined codes
    for (int c = 3; c < 8; c++) begin
      if (c == 4 || c == 5) continue;
      drive(1, 3'(c), 2'd0, 32'hFFFF_FFFF, 32'h1);
      chk("R9", {31'd0, misalign}, 1);
      chk("R9", {28'd0, byteEn}, 0);
      chk("R9", loadData, 0);
    end

    // random mix
    void'($urandom(32'd20250611));
    for (int n = 0; n < 3000; n++) begin
      applyAll(1'($urandom), 3'($urandom), 2'($urandom), $urandom, $urandom);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule